// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block gathers up to eight interrupt sources for a stack-machine core that has only one interrupt input. A rising edge on a source latches a pending flag. Software loads one handler address per channel through a small register bus. The block selects the most urgent channel that is both pending and enabled. It drives the request line to the core and offers that channel's handler address on a valid/ready port.

The block also decides whether the core may take the offered interrupt now. Nothing is offered while the core is inside an immediate-load sequence, so that sequence stays atomic. Nothing is offered while a debug-emulation event is asking for service, because that event outranks every interrupt. The block keeps a stack of in-service priority levels. Once a channel is accepted, only strictly more urgent channels can reach the core. The core's re-arm operation removes one level and restores the threshold that was in force before. Re-arm does not return from the handler. Software clears a pending flag itself, normally at the start of the handler.

Back-pressure on the vector port follows these rules. An offer is accepted in any cycle where `take_valid_o` and `take_ready_i` are both high. The core raises `take_ready_i` at an instruction boundary where it could take an event. While the offer is waiting, `take_valid_o` may fall, or its channel may change, without any acceptance. This happens when a more urgent source arrives, when a flag is cleared, when the enable mask changes, when an immediate-load sequence begins, or when a debug event appears. The core must therefore sample the channel and vector in the cycle of acceptance.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, every pending flag, enable bit and vector register is zero, and `irq_req_o`, `take_valid_o` and `dbg_grant_o` are low.
- R2: Word addresses 0 to 7 hold the vector of the channel with the same number, and address 9 holds the enable mask (bit n enables channel n). All of these are read/write. A read strobe returns the addressed value on `bus_rdata_o` one clock after the strobe. Addresses 10 to 15 read as zero.
- R3: A pending bit is set by a low-to-high change of its source and not by a high level, so a bit cleared while its source stays high remains clear. Address 8 reads the pending bits, and writing a 1 to bit n there clears pending bit n. If a source edge and a clear of the same bit fall in the same cycle, the bit ends up set.
- R4: The offered channel is the lowest-numbered channel that is both pending and enabled (channel 0 is the most urgent), and `take_vec_o` is that channel's vector register. A pending but disabled channel is never offered.
- R5: An offer is accepted in a cycle where `take_valid_o` and `take_ready_i` are both high. Accepting a channel does not clear its pending bit.
- R6: While `in_imm_i` is high, `take_valid_o` stays low and no acceptance takes place, while `irq_req_o` still shows the pending request.
- R7: `dbg_grant_o` is high exactly when `dbg_req_i` and `take_ready_i` are both high. While `dbg_req_i` is high, `take_valid_o` stays low.
- R8: After channel c is accepted, `irq_req_o` stays low for channel c and every higher-numbered channel until a re-arm, even if channel c fires again.
- R9: A channel numbered below the channel currently in service raises `irq_req_o` and can be accepted, which nests a further level.
- R10: A re-arm pulse on `rearm_i` removes exactly one in-service level and restores the threshold of the level beneath it. It leaves the pending bits untouched. A re-arm with no level in service has no effect.
- R11: A less urgent source that fires again, once or several times, while it is held off does not raise `irq_req_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 8 | Interrupt source lines, edge detected |
| bus_wr_i | input | 1 | Register write strobe |
| bus_rd_i | input | 1 | Register read strobe |
| bus_addr_i | input | 4 | Register word address |
| bus_wdata_i | input | 32 | Register write data |
| bus_rdata_o | output | 32 | Read data, valid one clock after the read strobe |
| in_imm_i | input | 1 | Core is inside an immediate-load sequence |
| dbg_req_i | input | 1 | Debug-emulation event request |
| dbg_grant_o | output | 1 | Debug event taken this cycle |
| rearm_i | input | 1 | Core executes the re-arm operation |
| irq_req_o | output | 1 | Interrupt request line to the core |
| take_valid_o | output | 1 | A channel is offered for acceptance |
| take_ready_i | input | 1 | Core is at a boundary where it can take an event |
| take_chan_o | output | 3 | Offered channel number |
| take_vec_o | output | 32 | Offered handler address |

## Verification
The request line, the offer, the channel, the vector and the debug grant are combinational. They follow the pending, enable and in-service state within the same cycle and follow the core inputs immediately. A pending bit, a register write and an acceptance or re-arm take effect at the next rising edge. Read data appears one edge after the read strobe. The bench drives every input on the falling edge and samples just after it, so a combinational result is checked in the half cycle of its stimulus and a registered one after exactly one rising edge. The held-off cases are sampled on every cycle of the repeated stimulus.

// File: rtl/pic_pkg.sv
package pic_pkg;

  // operation applied to the in-service level stack in one cycle
  typedef enum logic [1:0] {
    NST_HOLD = 2'd0,
    NST_PUSH = 2'd1,
    NST_POP  = 2'd2,
    NST_SWAP = 2'd3
  } nest_op_e;

endpackage

// File: rtl/pic_regfile.sv
module pic_regfile #(
  parameter int NCH = 8,
  parameter int VW  = 32,
  parameter int AW  = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NCH-1:0]           src_i,
  input  logic                     wr_i,
  input  logic                     rd_i,
  input  logic [AW-1:0]            addr_i,
  input  logic [VW-1:0]            wdata_i,
  output logic [VW-1:0]            rdata_o,
  output logic [NCH-1:0]           pend_o,
  output logic [NCH-1:0]           en_o,
  output logic [NCH-1:0][VW-1:0]   vec_o
);

  localparam logic [AW-1:0] PEND_ADR = AW'(NCH);
  localparam logic [AW-1:0] EN_ADR   = AW'(NCH + 1);

  logic [NCH-1:0]         src_q;
  logic [NCH-1:0]         pend_q;
  logic [NCH-1:0]         en_q;
  logic [NCH-1:0][VW-1:0] vec_q;
  logic [NCH-1:0]         rise;
  logic [NCH-1:0]         clr_mask;
  logic [VW-1:0]          rd_mux;
  logic [VW-1:0]          rdata_q;

  assign rise     = src_i & ~src_q;
  assign clr_mask = (wr_i && addr_i == PEND_ADR) ? wdata_i[NCH-1:0] : '0;

  // a new edge wins over a simultaneous clear
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_q  <= '0;
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      src_q  <= src_i;
      pend_q <= (pend_q & ~clr_mask) | rise;
      if (wr_i && addr_i == EN_ADR) en_q <= wdata_i[NCH-1:0];
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_vec
    always_ff @(posedge clk) begin
      if (!rst_n) vec_q[g] <= '0;
      else if (wr_i && addr_i == AW'(g)) vec_q[g] <= wdata_i;
    end

    AST_PEND_FROM_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pend_q[g]) |-> $past(src_i[g]) && !$past(src_q[g])); // R3
  end

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NCH; i++) begin
      if (addr_i == AW'(i)) rd_mux = vec_q[i];
    end
    if (addr_i == PEND_ADR) rd_mux = VW'(pend_q);
    if (addr_i == EN_ADR)   rd_mux = VW'(en_q);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    rdata_q <= '0;
    else if (rd_i) rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
  assign pend_o  = pend_q;
  assign en_o    = en_q;
  assign vec_o   = vec_q;

endmodule

// File: rtl/pic_select.sv
module pic_select #(
  parameter int NCH = 8,
  parameter int VW  = 32,
  parameter int CW  = 3
) (
  input  logic [NCH-1:0]         pend_i,
  input  logic [NCH-1:0]         en_i,
  input  logic [NCH-1:0][VW-1:0] vec_i,
  output logic                   hit_o,
  output logic [CW-1:0]          chan_o,
  output logic [VW-1:0]          vec_o
);

  logic [NCH-1:0] live;
  assign live = pend_i & en_i;

  // scan from least to most urgent so the lowest index is kept
  always_comb begin
    hit_o  = 1'b0;
    chan_o = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (live[i]) begin
        hit_o  = 1'b1;
        chan_o = CW'(i);
      end
    end
    vec_o = vec_i[chan_o];
  end

endmodule

// File: rtl/pic_nest.sv
module pic_nest
  import pic_pkg::*;
#(
  parameter int NCH = 8,
  parameter int CW  = 3,
  parameter int DW  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [CW-1:0] chan_i,
  input  logic          in_imm_i,
  input  logic          dbg_req_i,
  input  logic          take_ready_i,
  input  logic          rearm_i,
  output logic          irq_req_o,
  output logic          take_valid_o,
  output logic          dbg_grant_o
);

  localparam int LW = CW + 1;

  logic [CW-1:0] lvl_q [NCH];
  logic [DW-1:0] cnt_q;
  logic [DW-1:0] cnt_m1;
  logic [LW-1:0] thresh;
  logic          acc;
  logic          pop_ok;
  nest_op_e      op;

  assign cnt_m1 = cnt_q - DW'(1);
  assign thresh = (cnt_q == '0) ? LW'(NCH) : {1'b0, lvl_q[cnt_m1[CW-1:0]]};

  // strictly more urgent than the level in service
  assign irq_req_o    = hit_i && ({1'b0, chan_i} < thresh);
  assign take_valid_o = irq_req_o && !in_imm_i && !dbg_req_i;
  assign dbg_grant_o  = dbg_req_i && take_ready_i;

  assign acc    = take_valid_o && take_ready_i;
  assign pop_ok = rearm_i && (cnt_q != '0);

  always_comb begin
    if (acc && pop_ok) op = NST_SWAP;
    else if (acc)      op = NST_PUSH;
    else if (pop_ok)   op = NST_POP;
    else               op = NST_HOLD;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      for (int i = 0; i < NCH; i++) lvl_q[i] <= '0;
    end else begin
      case (op)
        NST_PUSH: begin
          lvl_q[cnt_q[CW-1:0]] <= chan_i;
          cnt_q <= cnt_q + DW'(1);
        end
        NST_POP:  cnt_q <= cnt_m1;
        NST_SWAP: lvl_q[cnt_m1[CW-1:0]] <= chan_i;
        default:  ;
      endcase
    end
  end

  AST_PUSH_DEPTH: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !rearm_i |=> cnt_q == $past(cnt_q) + DW'(1)); // R9

  AST_BLOCK_LOWER: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> !(irq_req_o && chan_i >= $past(chan_i))); // R8

  AST_REARM_POP: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i && !acc && cnt_q != '0 |=> cnt_q == $past(cnt_q) - DW'(1)); // R10

  AST_EMPTY_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    rearm_i && !acc && cnt_q == '0 |=> cnt_q == '0); // R10

endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
  parameter int NCH = 8,
  parameter int VW  = 32,
  localparam int AW = $clog2(NCH + 2),
  localparam int CW = $clog2(NCH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] src_i,
  input  logic           bus_wr_i,
  input  logic           bus_rd_i,
  input  logic [AW-1:0]  bus_addr_i,
  input  logic [VW-1:0]  bus_wdata_i,
  output logic [VW-1:0]  bus_rdata_o,
  input  logic           in_imm_i,
  input  logic           dbg_req_i,
  output logic           dbg_grant_o,
  input  logic           rearm_i,
  output logic           irq_req_o,
  output logic           take_valid_o,
  input  logic           take_ready_i,
  output logic [CW-1:0]  take_chan_o,
  output logic [VW-1:0]  take_vec_o
);

  localparam int DW = $clog2(NCH + 1);

  logic [NCH-1:0]         pend;
  logic [NCH-1:0]         en;
  logic [NCH-1:0][VW-1:0] vecs;
  logic                   hit;

  pic_regfile #(.NCH(NCH), .VW(VW), .AW(AW)) i_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_i   (src_i),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .pend_o  (pend),
    .en_o    (en),
    .vec_o   (vecs)
  );

  pic_select #(.NCH(NCH), .VW(VW), .CW(CW)) i_sel (
    .pend_i (pend),
    .en_i   (en),
    .vec_i  (vecs),
    .hit_o  (hit),
    .chan_o (take_chan_o),
    .vec_o  (take_vec_o)
  );

  pic_nest #(.NCH(NCH), .CW(CW), .DW(DW)) i_nest (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_i        (hit),
    .chan_i       (take_chan_o),
    .in_imm_i     (in_imm_i),
    .dbg_req_i    (dbg_req_i),
    .take_ready_i (take_ready_i),
    .rearm_i      (rearm_i),
    .irq_req_o    (irq_req_o),
    .take_valid_o (take_valid_o),
    .dbg_grant_o  (dbg_grant_o)
  );

  AST_ACCEPT_OUTSIDE_IMM: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o && take_ready_i |-> !in_imm_i); // R6

  AST_DEBUG_OUTRANKS: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o |-> !dbg_req_i); // R7

  AST_OFFER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o |-> pend[take_chan_o] && en[take_chan_o]); // R4

  AST_ACCEPT_KEEPS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take_valid_o && take_ready_i && !bus_wr_i |=> pend[$past(take_chan_o)]); // R5

endmodule

// File: tb/test_prio_irq_ctrl.sv
`timescale 1ns/1ps
module test_prio_irq_ctrl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  src = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        in_imm = 1'b0, dbg_req = 1'b0, rearm = 1'b0, take_ready = 1'b0;
  logic        dbg_grant, irq_req, take_valid;
  logic [2:0]  take_chan;
  logic [31:0] take_vec;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  prio_irq_ctrl i_prio_irq_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .src_i        (src),
    .bus_wr_i     (wr),
    .bus_rd_i     (rd),
    .bus_addr_i   (addr),
    .bus_wdata_i  (wdata),
    .bus_rdata_o  (rdata),
    .in_imm_i     (in_imm),
    .dbg_req_i    (dbg_req),
    .dbg_grant_o  (dbg_grant),
    .rearm_i      (rearm),
    .irq_req_o    (irq_req),
    .take_valid_o (take_valid),
    .take_ready_i (take_ready),
    .take_chan_o  (take_chan),
    .take_vec_o   (take_vec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // every input changes on the falling edge, outputs sampled 1 ns later
  task automatic fall();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    fall(); wr = 1'b1; addr = a; wdata = d;
    fall(); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    fall(); rd = 1'b1; addr = a;
    fall(); rd = 1'b0; settle(); d = rdata;
  endtask

  task automatic pulse_src(input int ch);
    fall(); src[ch] = 1'b1;
    fall(); src[ch] = 1'b0;
  endtask

  task automatic accept_now();
    fall(); take_ready = 1'b1;
    fall(); take_ready = 1'b0;
  endtask

  task automatic rearm_now();
    fall(); rearm = 1'b1;
    fall(); rearm = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    settle();
    chk("R1 irq_req", {31'd0, irq_req}, 32'd0);
    chk("R1 take_valid", {31'd0, take_valid}, 32'd0);
    chk("R1 dbg_grant", {31'd0, dbg_grant}, 32'd0);
    bus_read(4'd8, d); chk("R1 pending", d, 32'd0);
    bus_read(4'd9, d); chk("R1 enable", d, 32'd0);
    bus_read(4'd3, d); chk("R1 vector3", d, 32'd0);
  endtask

  task automatic t_regs();
    logic [31:0] d;
    for (int i = 0; i < 8; i++) bus_write(4'(i), 32'h1000 + 32'(i) * 4);
    bus_read(4'd0, d); chk("R2 vector0", d, 32'h1000);
    bus_read(4'd7, d); chk("R2 vector7", d, 32'h101C);
    bus_write(4'd9, 32'h5A);
    bus_read(4'd9, d); chk("R2 enable", d, 32'h5A);
    bus_write(4'd9, 32'hFF);
    bus_read(4'd10, d); chk("R2 unused addr", d, 32'd0);
  endtask

  task automatic t_pending();
    logic [31:0] d;
    fall(); src[5] = 1'b1;
    fall();
    bus_read(4'd8, d); chk("R3 edge sets", d, 32'h20);
    bus_write(4'd8, 32'h20);
    fall(); fall();
    bus_read(4'd8, d); chk("R3 level ignored", d, 32'h0);
    fall(); src[5] = 1'b0;
    fall(); src[4] = 1'b1; wr = 1'b1; addr = 4'd8; wdata = 32'h10;
    fall(); wr = 1'b0; src[4] = 1'b0;
    bus_read(4'd8, d); chk("R3 set beats clear", d, 32'h10);
    bus_write(4'd8, 32'hFF);
  endtask

  task automatic t_select();
    pulse_src(6); pulse_src(3);
    settle();
    chk("R4 chan", {29'd0, take_chan}, 32'd3);
    chk("R4 vec", take_vec, 32'h100C);
    bus_write(4'd9, 32'hF7);
    settle();
    chk("R4 disabled skipped", {29'd0, take_chan}, 32'd6);
    bus_write(4'd9, 32'hFF);
    bus_write(4'd8, 32'hFF);
    settle();
    chk("R4 idle", {31'd0, irq_req}, 32'd0);
  endtask

  task automatic t_imm();
    pulse_src(2);
    fall(); in_imm = 1'b1; take_ready = 1'b1; settle();
    chk("R6 irq_req shown", {31'd0, irq_req}, 32'd1);
    chk("R6 no offer", {31'd0, take_valid}, 32'd0);
    fall(); take_ready = 1'b0; in_imm = 1'b0; settle();
    chk("R6 not accepted", {31'd0, take_valid}, 32'd1);
  endtask

  task automatic t_dbg();
    fall(); dbg_req = 1'b1; take_ready = 1'b1; settle();
    chk("R7 grant", {31'd0, dbg_grant}, 32'd1);
    chk("R7 offer held", {31'd0, take_valid}, 32'd0);
    fall(); take_ready = 1'b0; settle();
    chk("R7 grant needs ready", {31'd0, dbg_grant}, 32'd0);
    fall(); dbg_req = 1'b0; settle();
    chk("R7 offer back", {31'd0, take_valid}, 32'd1);
  endtask

  task automatic t_nest();
    logic [31:0] d;
    logic bad;
    settle(); chk("R5 chan2 offered", {29'd0, take_chan}, 32'd2);
    accept_now(); settle();
    chk("R8 blocked after accept", {31'd0, irq_req}, 32'd0);
    bus_read(4'd8, d); chk("R5 pending kept", d, 32'h4);
    bad = 1'b0;
    for (int k = 0; k < 3; k++) begin
      fall(); src[5] = 1'b1; settle(); bad |= irq_req;
      fall(); src[5] = 1'b0; settle(); bad |= irq_req;
    end
    chk("R11 lower refire silent", {31'd0, bad}, 32'd0);
    pulse_src(2); settle();
    chk("R8 same channel refire", {31'd0, irq_req}, 32'd0);
    pulse_src(1); settle();
    chk("R9 higher nests", {31'd0, irq_req}, 32'd1);
    chk("R9 chan1", {29'd0, take_chan}, 32'd1);
    accept_now();
    bus_write(4'd8, 32'h02);
    rearm_now(); settle();
    chk("R10 prior threshold", {31'd0, irq_req}, 32'd0);
    bus_write(4'd8, 32'h04);
    rearm_now(); settle();
    chk("R10 empty again", {31'd0, irq_req}, 32'd1);
    chk("R10 chan5", {29'd0, take_chan}, 32'd5);
    bus_read(4'd8, d); chk("R10 pending untouched", d, 32'h20);
    rearm_now();
    accept_now(); settle();
    chk("R10 empty rearm harmless", {31'd0, irq_req}, 32'd0);
    rearm_now(); settle();
    chk("R10 single pop", {31'd0, irq_req}, 32'd1);
    bus_write(4'd8, 32'hFF);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    fall(); rst_n = 1'b1;
    t_reset();
    t_regs();
    t_pending();
    t_select();
    t_imm();
    t_dbg();
    t_nest();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++;
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule